// File: doc/BRIEF.md
# Power-on configuration loader with retry

This block fills a set of configuration registers from an external serial EEPROM as soon as reset is released. It fetches a fixed-length image one byte at a time through a request/acknowledge handshake. The image is sixteen configuration bytes followed by one check byte. Incoming bytes go into a shadow buffer while a CRC-8 is accumulated over them. Only when the received check byte matches the accumulated CRC are the shadow contents copied into the live registers that downstream logic reads.

While a load is in progress the block asks the board to pull the active-low fault line down and forces the serial data output high. A mismatch, or a byte that never arrives within a cycle budget, restarts the load from the first address. Corrupted transfers, a blank part and an absent part are all handled by this one restart path. After the third failed attempt in a row the block stops fetching for good. The fault line then stays asserted and the valid flag stays low until the next reset. A successful load releases both pins, raises the valid level and emits a one-cycle done pulse.

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `rd_req` is 1 with `rd_addr` = 0, `err_low` = 1, `slo_high` = 1, `cfg_valid` = 0 and `done` = 0.
- R2: During a load, `rd_addr` steps 0, 1, …, 16, advancing by one on each cycle in which `rd_ack` is 1. While `rd_ack` is 0, `rd_req` stays 1 and the address holds, unless a timeout restarts the load at 0.
- R3: The check is CRC-8 with polynomial 0x07 and initial value 0x00, processed MSB first, with no final XOR. It runs over the bytes at addresses 0 to 15. The byte at address 16 must equal the result.
- R4: When the check byte matches, from the next cycle on `cfg_valid` = 1, `err_low` = 0 and `slo_high` = 0, and `done` is 1 for exactly that one cycle. `cfg_regs[8k+7:8k]` holds the byte read from address k.
- R5: When the check byte does not match, the next cycle requests address 0 again, and `err_low` and `slo_high` stay 1.
- R6: If `rd_ack` stays 0 for TIMEOUT (default 64) consecutive cycles of a request, the attempt fails and the load restarts at address 0. With no response at all, the third failure takes effect at clock edge 3·TIMEOUT after reset release.
- R7: After three consecutive failed attempts, `rd_req` = 0, `err_low` = 1, `slo_high` = 1, `cfg_valid` = 0 and no `done` pulse occurs, until the next reset.
- R8: Once `cfg_valid` is 1, `rd_req` stays 0, and any activity on `rd_ack` and `rd_data` leaves `cfg_regs` unchanged. Live registers are written only by a passing load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Byte fetch request to the EEPROM front end |
| rd_addr | output | 5 | Byte address of the current request |
| rd_ack | input | 1 | One-cycle strobe: `rd_data` is valid for `rd_addr` |
| rd_data | input | 8 | Returned byte |
| err_low | output | 1 | 1 = pull the open-drain fault pin low |
| slo_high | output | 1 | 1 = force the serial data output high |
| done | output | 1 | One-cycle pulse when a load commits |
| cfg_valid | output | 1 | Live configuration valid, normal operation allowed |
| cfg_regs | output | 128 | Live configuration bytes, byte k at bits 8k+7:8k |

## Verification
A wrong sequencing state appears at once on `rd_req`, `err_low` and `slo_high`, because all three follow the state register directly. A miscounted attempt counter shows as a fault or a commit one load too early or too late. A slipped byte index or a corrupted CRC register shows up within one load: it either sends a good image into the fault path or puts a byte in the wrong slot of `cfg_regs` on commit. An off-by-one in the timeout counter shifts the no-response fault edge by three cycles, since three attempts are chained, and a cycle-exact check exposes it.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/cfg_crc8_step.sv
module cfg_crc8_step #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    always_comb begin
        logic [7:0] c;
        c = crc_in ^ data_in;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/cfg_live_bank.sv
module cfg_live_bank #(
    parameter int NB = 16
) (
    input  logic            clk,
    input  logic            load,
    input  logic [NB*8-1:0] shadow_in,
    output logic [NB*8-1:0] regs_out
);
    // No reset: contents are undefined until a load passes its check.
    logic [NB*8-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (load) begin
            regs_q <= shadow_in;
        end
    end

    assign regs_out = regs_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int         NB        = 16,
    parameter int         TIMEOUT   = 64,
    parameter int         MAX_TRIES = 3,
    parameter logic [7:0] POLY      = 8'h07,
    localparam int        AW        = $clog2(NB + 1),
    localparam int        TW        = $clog2(TIMEOUT),
    localparam int        TRW       = $clog2(MAX_TRIES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 rd_req,
    output logic [AW-1:0]        rd_addr,
    input  logic                 rd_ack,
    input  logic [BYTE_W-1:0]    rd_data,
    output logic                 err_low,
    output logic                 slo_high,
    output logic                 done,
    output logic                 cfg_valid,
    output logic [NB*BYTE_W-1:0] cfg_regs
);
    typedef struct packed {
        ld_state_e                     st;
        logic [AW-1:0]                 idx;
        logic [TW-1:0]                 wait_c;
        logic [TRW-1:0]                tries;
        logic [BYTE_W-1:0]             crc;
        logic [NB-1:0][BYTE_W-1:0]     shadow;
        logic                          done;
    } ld_regs_t;

    ld_regs_t   s_q, s_d;
    logic [7:0] crc_nxt;
    logic       commit;
    logic       fail;

    cfg_crc8_step #(.POLY(POLY)) u_crc (
        .crc_in  (s_q.crc),
        .data_in (rd_data),
        .crc_out (crc_nxt)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        commit   = 1'b0;
        fail     = 1'b0;
        if (s_q.st == ST_FETCH) begin
            if (rd_ack) begin
                s_d.wait_c = '0;
                if (s_q.idx == AW'(NB)) begin
                    if (rd_data == s_q.crc) begin
                        s_d.st   = ST_RUN;
                        s_d.done = 1'b1;
                        commit   = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end else begin
                    for (int k = 0; k < NB; k++) begin
                        if (s_q.idx == AW'(k)) begin
                            s_d.shadow[k] = rd_data;
                        end
                    end
                    s_d.crc = crc_nxt;
                    s_d.idx = s_q.idx + 1'b1;
                end
            end else if (s_q.wait_c == TW'(TIMEOUT - 1)) begin
                fail = 1'b1;
            end else begin
                s_d.wait_c = s_q.wait_c + 1'b1;
            end
            if (fail) begin
                s_d.idx    = '0;
                s_d.crc    = '0;
                s_d.wait_c = '0;
                if (s_q.tries == TRW'(MAX_TRIES - 1)) begin
                    s_d.st = ST_FAULT;
                end else begin
                    s_d.tries = s_q.tries + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_FETCH;
        end else begin
            s_q <= s_d;
        end
    end

    cfg_live_bank #(.NB(NB)) u_live (
        .clk       (clk),
        .load      (commit),
        .shadow_in (s_q.shadow),
        .regs_out  (cfg_regs)
    );

    assign rd_req    = (s_q.st == ST_FETCH);
    assign rd_addr   = s_q.idx;
    assign err_low   = (s_q.st != ST_RUN);
    assign slo_high  = (s_q.st != ST_RUN);
    assign cfg_valid = (s_q.st == ST_RUN);
    assign done      = s_q.done;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int NB = 16,
    parameter int AW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_req,
    input logic [AW-1:0]   rd_addr,
    input logic            rd_ack,
    input logic            err_low,
    input logic            slo_high,
    input logic            done,
    input logic            cfg_valid,
    input logic [NB*8-1:0] cfg_regs
);
    assert_load_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (err_low && slo_high && !cfg_valid));

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr <= AW'(NB)));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req || !cfg_valid) && (rd_addr == $past(rd_addr) || rd_addr == '0));

    assert_run_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (!err_low && !slo_high));

    assert_done_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cfg_valid));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !cfg_valid) |=> (!rd_req && !cfg_valid && err_low && !done));

    assert_regs_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (cfg_valid && !rd_req && $stable(cfg_regs)));
endmodule

bind cfg_loader cfg_loader_chk #(.NB(NB), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .err_low   (err_low),
    .slo_high  (slo_high),
    .done      (done),
    .cfg_valid (cfg_valid),
    .cfg_regs  (cfg_regs)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
    localparam int NB = 16;
    localparam int T  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req;
    logic [4:0]    rd_addr;
    logic          rd_ack = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          err_low, slo_high, done, cfg_valid;
    logic [NB*8-1:0] cfg_regs;

    int total = 0;
    int bad = 0;

    logic [7:0] img [0:NB];
    int bad_tries = 0;
    int mode = 0;
    int max_delay = 0;
    int att = 0;
    int delay = 0;
    int exp_addr = 0;
    int addr_err = 0;
    int done_cnt = 0;
    bit mem_en = 1'b1;
    bit garbage = 1'b0;

    always #2 clk = ~clk;

    cfg_loader #(.NB(NB), .TIMEOUT(T)) dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .err_low(err_low),
        .slo_high(slo_high), .done(done), .cfg_valid(cfg_valid),
        .cfg_regs(cfg_regs)
    );

    function automatic logic [7:0] crc8(input logic [7:0] bytes [0:NB]);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < NB; i++) begin
            c ^= bytes[i];
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // EEPROM front-end model, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rd_ack = 1'b0;
            end else if (garbage) begin
                rd_ack  = 1'($urandom_range(0, 1));
                rd_data = 8'($urandom);
            end else if (rd_ack) begin
                rd_ack = 1'b0;
                delay  = $urandom_range(0, max_delay);
            end else if (rd_req && mem_en) begin
                if (mode == 1 && att <= bad_tries && att > 0 && rd_addr == 5'd5) begin
                    exp_addr = 0;   // stall: the design must time out and restart
                end else if (delay == 0) begin
                    if (rd_addr == 5'd0) att++;
                    if (int'(rd_addr) != exp_addr) addr_err++;
                    exp_addr = (exp_addr == NB) ? 0 : exp_addr + 1;
                    rd_ack  = 1'b1;
                    rd_data = img[rd_addr];
                    if (rd_addr == 5'(NB) && mode == 0 && att <= bad_tries) rd_data = img[NB] ^ 8'h5A;
                end else begin
                    delay--;
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) done_cnt++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        att = 0; exp_addr = 0; addr_err = 0; done_cnt = 0; delay = 0;
        garbage = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic make_image(input bit blank);
        for (int i = 0; i < NB; i++) img[i] = blank ? 8'hFF : 8'($urandom);
        img[NB] = blank ? 8'hFF : crc8(img);
    endtask

    task automatic run_case(input int nbad, input int md, input int dly, input bit blank);
        bit exp_pass;
        int exp_att;
        logic [NB*8-1:0] exp_regs;
        logic [NB*8-1:0] held;
        int n = 0;
        make_image(blank);
        bad_tries = nbad; mode = md; max_delay = dly; mem_en = 1'b1;
        exp_pass = blank ? (crc8(img) == img[NB]) : (nbad < 3);
        exp_att  = exp_pass ? ((nbad < 3) ? nbad + 1 : 3) : 3;
        for (int i = 0; i < NB; i++) exp_regs[i*8 +: 8] = img[i];
        do_reset();
        while (!cfg_valid && rd_req && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check("R4/R5/R7 cfg_valid", 128'(cfg_valid), 128'(exp_pass));
        check("R4/R7 err_low", 128'(err_low), 128'(!exp_pass));
        check("R4/R7 slo_high", 128'(slo_high), 128'(!exp_pass));
        check("R4/R7 done count", 128'(done_cnt), 128'(exp_pass));
        check("R5/R6 attempts", 128'(att), 128'(exp_att));
        check("R2 address sequence errors", 128'(addr_err), 128'(0));
        check("R7/R8 rd_req idle", 128'(rd_req), 128'(0));
        if (exp_pass) begin
            check("R3/R4 cfg_regs", 128'(cfg_regs), 128'(exp_regs));
            held = cfg_regs;
            garbage = 1'b1;
            repeat (20) @(negedge clk);
            garbage = 1'b0;
            @(negedge clk);
            check("R8 cfg_regs unchanged by stray acks", 128'(cfg_regs), 128'(held));
            check("R8 cfg_valid kept", 128'(cfg_valid), 128'(1));
        end else begin
            repeat (50) @(negedge clk);
            check("R7 fault held valid", 128'(cfg_valid), 128'(0));
            check("R7 fault held err_low", 128'(err_low), 128'(1));
        end
    endtask

    initial begin
        #(4 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        make_image(1'b0);
        // R1 reset state
        mem_en = 1'b0;
        #1;
        @(negedge clk);
        check("R1 rd_req in reset", 128'(rd_req), 128'(1));
        check("R1 rd_addr in reset", 128'(rd_addr), 128'(0));
        check("R1 err_low in reset", 128'(err_low), 128'(1));
        check("R1 slo_high in reset", 128'(slo_high), 128'(1));
        check("R1 cfg_valid in reset", 128'(cfg_valid), 128'(0));
        check("R1 done in reset", 128'(done), 128'(0));
        // R6 no response at all: fault at edge 3*T after release
        do_reset();
        @(negedge clk);
        check("R1 rd_req after release", 128'(rd_req), 128'(1));
        repeat (3 * T - 2) @(negedge clk);
        check("R6 still fetching before edge 3T", 128'(rd_req), 128'(1));
        @(negedge clk);
        check("R6/R7 fault at edge 3T", 128'(rd_req), 128'(0));
        check("R7 err_low after timeouts", 128'(err_low), 128'(1));
        // directed corners
        run_case(0, 0, 0, 1'b0);   // clean, back-to-back acks
        run_case(1, 0, 2, 1'b0);   // one CRC failure, R5
        run_case(2, 1, 1, 1'b0);   // two timeouts then good, R6
        run_case(3, 0, 1, 1'b0);   // three CRC failures, R7
        run_case(3, 1, 0, 1'b0);   // three timeouts, R7
        run_case(0, 0, 1, 1'b1);   // blank part, R3
        // constrained random
        for (int r = 0; r < 8; r++) begin
            run_case($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3), 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule